// File: doc/BRIEF.md
# Two-line edge-triggered interrupt bank with primary aggregator

The block gathers edge events from a group of interrupt sources and reports them on two independent active-low interrupt lines. Each bank holds up to 24 sources. Every source passes through a two-flop synchronizer and then an edge detector, which can be programmed for rising edges, falling edges, both or neither. One edge configuration is shared by both lines. Each line keeps its own status register, which records events, and its own mask register, which decides what that line may see. Two hosts can therefore each own one line and service the same sources without disturbing each other.

Status is cleared in one of two ways, chosen by a control bit. In the first mode a read of a line's status clears the bits it returned. In the second mode the host writes ones to the bits it wants cleared. A pending-buffer option holds a second edge that arrives while the status bit is still set, so that one clear does not lose it. The top level instantiates several banks behind one synchronous register port. For each line it forms a primary status vector with one bit per bank, where bit n is bank n. The host services the lowest set bit first.

Top module: `sih_hub`

## Requirements
- R1: After synchronous reset every mask bit is 1, all status, pending and edge-select bits are 0, the control register is 0, and both `irq_n` outputs are high.
- R2: Each source has an edge-select pair. The upper bit of the pair enables rising-edge detection and the lower bit enables falling-edge detection. A selected edge on a source input sets the matching status bit within 3 clocks of the input change.
- R3: The pair for source i sits at bits 2i+1:2i of a 2×NSRC-bit edge vector, which is four sources per byte. Register 1 holds vector bits 31:0 and register 2 holds bits 63:32.
- R4: A source whose edge-select pair is 00 never sets a status bit on either line.
- R5: Each line has its own status register (register 3 for line 0, register 5 for line 1) and its own mask register (register 4 for line 0, register 6 for line 1). One edge event on an unmasked source sets the bit on both lines. Clearing one line leaves the other line unchanged.
- R6: A mask bit of 1 stops its source from setting status on that line. `irq_n[l]` is low exactly while some bank has a status bit set with its mask bit clear on line l.
- R7: The control register is register 0, with bit 0 selecting clear-on-read and bit 1 enabling the pending buffer. With bit 0 set, a status read clears the bits returned. With bit 0 clear, writing 1s clears those bits and reads do not clear anything.
- R8: With the pending buffer on, a second edge that arrives while the status bit is set is held. After the next clear the status bit reads 1 again. With the buffer off, the same clear leaves the bit at 0.
- R9: A status bit set on the same clock as a clear-on-read of that register survives the clear and is returned by the following read.
- R10: Status, mask and edge bits at or above the configured source count (NSRC, or 2×NSRC for edge bits) read back as 0, and writes to them are ignored.
- R11: `prim_stat0[n]` and `prim_stat1[n]` are high while bank n drives line 0 or line 1 respectively. The address is {bank, register}, and each bank's registers are independent.
- R12: Read data is registered and appears the clock after the read strobe. Register 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | NBANK*NSRC | Source inputs; bank b uses bits b*NSRC+NSRC-1 : b*NSRC |
| addr | input | BAW+3 | {bank index, register index} |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid one clock after `rd` |
| prim_stat0 | output | NBANK | Per-bank request on line 0 |
| prim_stat1 | output | NBANK | Per-bank request on line 1 |
| irq_n | output | 2 | Active-low interrupt outputs, index = line |

## Verification
The bench drives an edge that lands in the same clock as a clear-on-read. A design that clears the whole register would then return 0 on the second read instead of the new bit. It clears one line and checks that the other keeps its bit, which catches status that is wrongly shared between lines. It sends a second edge with the pending buffer on and then off: a missing buffer loses that event, and a buffer that is always on keeps a bit that should have gone. It also writes source 17's pair in the upper edge register, toggles a source whose pair is 00, and writes ones above the source count, which exposes wrong packing, events from disabled sources and stray high bits.

// File: rtl/sih_pkg.sv
package sih_pkg;
    localparam int DW    = 32;
    localparam int RAW   = 3;
    localparam int NLINE = 2;

    typedef enum logic [RAW-1:0] {
        REG_CTRL    = 3'd0,
        REG_EDGE_LO = 3'd1,
        REG_EDGE_HI = 3'd2,
        REG_STAT0   = 3'd3,
        REG_MASK0   = 3'd4,
        REG_STAT1   = 3'd5,
        REG_MASK1   = 3'd6
    } reg_e;

    typedef struct packed {
        logic pend_en;
        logic cor;
    } ctrl_t;

    function automatic logic [RAW-1:0] stat_addr(input int line);
        return RAW'(3 + 2 * line);
    endfunction

    function automatic logic [RAW-1:0] mask_addr(input int line);
        return RAW'(4 + 2 * line);
    endfunction
endpackage

// File: rtl/sih_edge.sv
module sih_edge #(
    parameter int NSRC = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSRC-1:0]     src,
    input  logic [2*NSRC-1:0]   esel,
    output logic [NSRC-1:0]     evt
);
    logic [NSRC-1:0] sync1, sync2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= src;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_det
        assign evt[i] = (esel[2*i+1] &  sync2[i] & ~prev[i])
                      | (esel[2*i]   & ~sync2[i] &  prev[i]);
    end
endmodule

// File: rtl/sih_line.sv
module sih_line #(
    parameter int NSRC = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  evt,
    input  logic             mask_wr,
    input  logic [NSRC-1:0]  wdata,
    input  logic [NSRC-1:0]  clr,
    input  logic             pend_en,
    output logic [NSRC-1:0]  stat,
    output logic [NSRC-1:0]  mask,
    output logic             req
);
    logic [NSRC-1:0] pend, setv, stat_n, pend_n;

    assign setv   = evt & ~mask;
    assign stat_n = (stat & ~clr) | setv | (pend & clr);
    assign pend_n = pend_en ? ((pend & ~clr) | (setv & stat & ~clr) | (pend & clr & setv))
                            : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            pend <= '0;
            mask <= '1;
        end else begin
            stat <= stat_n;
            pend <= pend_n;
            if (mask_wr) mask <= wdata;
        end
    end

    assign req = |(stat & ~mask);

    // R6: no status bit appears under a set mask bit
    assert_masked_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ((stat & ~$past(stat) & $past(mask)) == '0));

    // R7: a status bit only falls when a clear was requested
    assert_no_silent_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (($past(stat) & ~stat & ~$past(clr)) == '0));

    // R8: a held edge exists only behind a set status bit
    assert_pend_subset_R8: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~stat) == '0));
endmodule

// File: rtl/sih_bank.sv
module sih_bank
    import sih_pkg::*;
#(
    parameter int NSRC = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSRC-1:0]     src,
    input  logic                sel,
    input  logic [RAW-1:0]      addr,
    input  logic [DW-1:0]       wdata,
    input  logic                wr,
    input  logic                rd,
    output logic [DW-1:0]       rdata,
    output logic [NLINE-1:0]    req
);
    localparam int EW = 2 * NSRC;

    ctrl_t                       ctrl;
    logic [EW-1:0]               esel;
    logic [2*DW-1:0]             esel_wide;
    logic [NSRC-1:0]             evt, dead;
    logic [NLINE-1:0][NSRC-1:0]  stat, mask, clr;
    logic [DW-1:0]               rnext;

    assign esel_wide = {{(2*DW-EW){1'b0}}, esel};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            esel <= '0;
        end else if (wr && sel) begin
            case (addr)
                REG_CTRL:    ctrl <= ctrl_t'(wdata[1:0]);
                REG_EDGE_LO: esel <= EW'({esel_wide[2*DW-1:DW], wdata});
                REG_EDGE_HI: esel <= EW'({wdata, esel_wide[DW-1:0]});
                default: ;
            endcase
        end
    end

    sih_edge #(.NSRC(NSRC)) u_edge (
        .clk(clk), .rst(rst), .src(src), .esel(esel), .evt(evt)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_dead
        assign dead[i] = ~|esel[2*i +: 2];
    end

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        logic hit;
        assign hit    = sel && (addr == stat_addr(l));
        assign clr[l] = !hit     ? '0 :
                        ctrl.cor ? (rd ? stat[l] : '0) :
                                   (wr ? wdata[NSRC-1:0] : '0);

        sih_line #(.NSRC(NSRC)) u_line (
            .clk(clk), .rst(rst), .evt(evt),
            .mask_wr(wr && sel && (addr == mask_addr(l))),
            .wdata(wdata[NSRC-1:0]), .clr(clr[l]), .pend_en(ctrl.pend_en),
            .stat(stat[l]), .mask(mask[l]), .req(req[l])
        );

        // R4: a source with edge pair 00 never raises status
        assert_dead_source_R4: assert property (@(posedge clk) disable iff (rst)
            ((stat[l] & ~$past(stat[l]) & $past(dead)) == '0));
    end

    always_comb begin
        case (addr)
            REG_CTRL:    rnext = DW'(ctrl);
            REG_EDGE_LO: rnext = esel_wide[DW-1:0];
            REG_EDGE_HI: rnext = esel_wide[2*DW-1:DW];
            REG_STAT0:   rnext = DW'(stat[0]);
            REG_MASK0:   rnext = DW'(mask[0]);
            REG_STAT1:   rnext = DW'(stat[1]);
            REG_MASK1:   rnext = DW'(mask[1]);
            default:     rnext = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= sel ? rnext : '0;
    end

    if (NSRC < DW) begin : g_hi_chk
        // R10: status and mask reads carry nothing above the source count
        assert_rdata_hi_R10: assert property (@(posedge clk) disable iff (rst)
            ($past(rd && sel && (addr >= REG_STAT0) && (addr <= REG_MASK1)))
            |-> (rdata[DW-1:NSRC] == '0));
    end
endmodule

// File: rtl/sih_hub.sv
module sih_hub
    import sih_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int NSRC  = 24,
    localparam int BAW  = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int AW   = BAW + RAW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NBANK*NSRC-1:0]   src,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic                    wr,
    input  logic                    rd,
    output logic [DW-1:0]           rdata,
    output logic [NBANK-1:0]        prim_stat0,
    output logic [NBANK-1:0]        prim_stat1,
    output logic [NLINE-1:0]        irq_n
);
    logic [NBANK-1:0][DW-1:0]     bank_rd;
    logic [NBANK-1:0][NLINE-1:0]  bank_req;
    logic [NLINE-1:0][NBANK-1:0]  prim;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sih_bank #(.NSRC(NSRC)) u_bank (
            .clk(clk), .rst(rst), .src(src[b*NSRC +: NSRC]),
            .sel(addr[AW-1:RAW] == BAW'(b)), .addr(addr[RAW-1:0]),
            .wdata(wdata), .wr(wr), .rd(rd),
            .rdata(bank_rd[b]), .req(bank_req[b])
        );
        for (genvar l = 0; l < NLINE; l++) begin : g_map
            assign prim[l][b] = bank_req[b][l];
        end
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NBANK; b++) rdata |= bank_rd[b];
    end

    for (genvar l = 0; l < NLINE; l++) begin : g_out
        assign irq_n[l] = ~|prim[l];
    end

    assign prim_stat0 = prim[0];
    assign prim_stat1 = prim[1];
endmodule

// File: tb/sim_sih_hub.sv
module sim_sih_hub;
    localparam int NBANK = 2;
    localparam int NSRC  = 24;

    logic                  clk = 0;
    logic                  rst = 1;
    logic [NBANK*NSRC-1:0] src = '0;
    logic [3:0]            addr = '0;
    logic [31:0]           wdata = '0;
    logic                  wr = 0, rd = 0, rd_d = 0;
    logic [31:0]           rdata;
    logic [1:0]            prim_stat0, prim_stat1, irq_n;

    int total = 0, bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    sih_hub #(.NBANK(NBANK), .NSRC(NSRC)) u0 (
        .clk(clk), .rst(rst), .src(src), .addr(addr), .wdata(wdata),
        .wr(wr), .rd(rd), .rdata(rdata), .prim_stat0(prim_stat0),
        .prim_stat1(prim_stat1), .irq_n(irq_n)
    );

    always @(posedge clk) rd_d <= rd;

    // monitor: pops the expected read value and compares
    always @(negedge clk) begin
        if (rd_d) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL read with no expectation: got %h", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    bad++;
                    $display("FAIL %s: got %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr_reg(input int b, input int r, input logic [31:0] d);
        addr = 4'({b[0], r[2:0]}); wdata = d; wr = 1;
        @(negedge clk); wr = 0;
    endtask

    task automatic rd_chk(input int b, input int r, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        addr = 4'({b[0], r[2:0]}); rd = 1;
        @(negedge clk); rd = 0;
    endtask

    task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
        total++;
        if (got !== e) begin
            bad++;
            $display("FAIL %s: got %h expected %h", t, got, e);
        end
    endtask

    task automatic drive(input int idx, input logic v);
        src[idx] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd_chk(0, 4, 32'h00FF_FFFF, "R1 mask0 reset");
        rd_chk(0, 6, 32'h00FF_FFFF, "R1 mask1 reset");
        rd_chk(0, 3, 0, "R1 stat0 reset");
        rd_chk(0, 1, 0, "R1 edge reset");
        rd_chk(0, 0, 0, "R1 ctrl reset");
        chk(32'(irq_n), 3, "R1 irq_n reset");
        // R4 pair 00 never records
        wr_reg(0, 4, 0);
        drive(0, 1); drive(0, 0);
        rd_chk(0, 3, 0, "R4 disabled source");
        chk(32'(irq_n), 3, "R4 line stays high");
        // R2 rising on source 0
        wr_reg(0, 1, 32'h2);
        drive(0, 1);
        rd_chk(0, 3, 32'h1, "R2 rising sets");
        chk(32'(irq_n), 2, "R6 line0 low line1 high");
        chk(32'(prim_stat0), 1, "R11 prim0 bank0");
        rd_chk(0, 5, 0, "R6 masked line1 not recorded");
        rd_chk(0, 3, 32'h1, "R7 read keeps bit in w1c mode");
        drive(0, 0);
        rd_chk(0, 3, 32'h1, "R2 falling ignored when rising only");
        wr_reg(0, 3, 32'h1);
        rd_chk(0, 3, 0, "R7 write one clears");
        chk(32'(irq_n), 3, "R6 line released");
        // R2 falling on source 5 (bit 10)
        wr_reg(0, 1, 32'h400);
        drive(5, 1);
        rd_chk(0, 3, 0, "R2 rise ignored when falling only");
        drive(5, 0);
        rd_chk(0, 3, 32'h20, "R2 falling sets");
        wr_reg(0, 3, 32'h20);
        // R3 source 17 lives at edge bit 35 = upper register bit 3
        wr_reg(0, 2, 32'h8);
        drive(17, 1);
        rd_chk(0, 3, 32'h2_0000, "R3 source 17 packing");
        wr_reg(0, 3, 32'h2_0000);
        wr_reg(0, 2, 0);
        // both edges on source 2
        wr_reg(0, 1, 32'h30);
        drive(2, 1);
        rd_chk(0, 3, 32'h4, "R2 both edges rise");
        wr_reg(0, 3, 32'h4);
        drive(2, 0);
        rd_chk(0, 3, 32'h4, "R2 both edges fall");
        wr_reg(0, 3, 32'h4);
        // R5 line independence
        wr_reg(0, 6, 0);
        wr_reg(0, 1, 32'h32);
        drive(0, 1);
        rd_chk(0, 3, 32'h1, "R5 line0 set");
        rd_chk(0, 5, 32'h1, "R5 line1 set");
        wr_reg(0, 3, 32'h1);
        rd_chk(0, 3, 0, "R5 line0 cleared");
        rd_chk(0, 5, 32'h1, "R5 line1 kept");
        chk(32'(irq_n), 1, "R5 only line1 low");
        wr_reg(0, 5, 32'h1);
        chk(32'(irq_n), 3, "R5 both high");
        // R7 clear on read
        wr_reg(0, 0, 32'h1);
        drive(2, 1);
        rd_chk(0, 3, 32'h4, "R7 cor first read");
        rd_chk(0, 3, 0, "R7 cor second read");
        rd_chk(0, 5, 32'h4, "R7 line1 untouched by line0 read");
        rd_chk(0, 5, 0, "R7 line1 cor");
        // R9 set in the same clock as the clearing read
        drive(0, 0);
        drive(2, 0);
        src[0] = 1;
        @(negedge clk); @(negedge clk);
        rd_chk(0, 3, 32'h4, "R9 read returns old bits");
        rd_chk(0, 3, 32'h1, "R9 coincident event survives");
        rd_chk(0, 5, 32'h5, "R9 line1 both bits");
        rd_chk(0, 5, 0, "R9 line1 cleared");
        // R8 pending buffer on
        wr_reg(0, 0, 32'h2);
        drive(0, 0); drive(0, 1); drive(0, 0); drive(0, 1);
        wr_reg(0, 3, 32'h1);
        rd_chk(0, 3, 32'h1, "R8 held edge reappears");
        wr_reg(0, 3, 32'h1);
        rd_chk(0, 3, 0, "R8 second clear empties");
        wr_reg(0, 5, 32'h1); wr_reg(0, 5, 32'h1);
        // R8 pending buffer off
        wr_reg(0, 0, 32'h0);
        drive(0, 0); drive(0, 1); drive(0, 0); drive(0, 1);
        wr_reg(0, 3, 32'h1);
        rd_chk(0, 3, 0, "R8 no buffer loses second edge");
        wr_reg(0, 5, 32'h1);
        // R10 bits above the source count
        wr_reg(0, 4, 32'hFFFF_FFFF);
        rd_chk(0, 4, 32'h00FF_FFFF, "R10 mask upper bits");
        wr_reg(0, 2, 32'hFFFF_FFFF);
        rd_chk(0, 2, 32'h0000_FFFF, "R10 edge upper bits");
        wr_reg(0, 2, 0);
        wr_reg(0, 3, 32'hFF00_0000);
        rd_chk(0, 3, 0, "R10 status upper bits");
        wr_reg(0, 4, 0);
        // R11 aggregator across banks
        wr_reg(1, 1, 32'h2);
        wr_reg(1, 4, 0);
        drive(24, 1);
        chk(32'(prim_stat0), 2, "R11 prim0 bank1");
        chk(32'(prim_stat1), 0, "R11 prim1 idle");
        chk(32'(irq_n), 2, "R11 line0 from bank1");
        rd_chk(1, 3, 32'h1, "R11 bank1 status");
        rd_chk(0, 3, 0, "R11 bank0 untouched");
        drive(0, 0); drive(0, 1);
        chk(32'(prim_stat0), 3, "R11 prim0 both banks");
        chk(32'(prim_stat1), 1, "R11 prim1 bank0");
        chk(32'(irq_n), 0, "R11 both lines low");
        // R12 unmapped register
        rd_chk(0, 7, 0, "R12 unmapped reads zero");
        repeat (3) @(negedge clk);
        chk(32'(exp_q.size()), 0, "R12 all reads returned");
        finish_run();
    end
endmodule